// File: doc/BRIEF.md
# Triggered Waveform Playback Buffer

This block holds a transmit waveform in an on-chip dual-port store and plays it out once each time software asks for it. Signed 16-bit samples come in on a stream write port (data, valid, last) and are written at a running write pointer. Three control levels, meant to be driven from memory-mapped registers outside the block, set the index of the last sample to play, choose whether the burst comes from the store or from an internal counting ramp, and launch the burst.

During a burst the block advances one sample on each clock where the sample enable is high. It drives the same value on its I and Q baseband outputs together with a valid flag. In the cycle a burst is launched it also raises a one-cycle pulse, so that a companion capture block starts receiving at the same moment the transmission starts.

Top module: `wave_burst_player`

## Requirements
- R1: Every clock with `s_tvalid` high writes `s_tdata` into the store at the current write pointer. When `s_tlast` is low the pointer then moves up by one, wrapping from 2^ADDR_W-1 to 0.
- R2: A launch latches `cfg_last_idx` as N. The burst then presents exactly N+1 valid samples, taken from store addresses 0,1,...,N in that order. N may be anything up to 2^ADDR_W-1 (2047 by default). Changing `cfg_last_idx` during a burst has no effect on it.
- R3: After the sample at index N the block stops. `tx_valid` stays low even if `cfg_fire` remains high.
- R4: The source choice is latched at launch. `cfg_use_ramp` = 1 gives sample k = k, restarting from 0 on every burst. `cfg_use_ramp` = 0 gives the stored data. Changing `cfg_use_ramp` during a burst has no effect on it.
- R5: `tx_i` always equals `tx_q`. Both read 0 whenever `tx_valid` is low.
- R6: `rx_start` is high for exactly one cycle, right after the clock edge at which the launch is taken. The first sample appears after the next clock edge where `sample_en` is high.
- R7: Only a 0-to-1 transition of `cfg_fire` launches a burst. A transition that arrives while a burst is running is ignored: no `rx_start` pulse, and the running burst neither restarts nor grows longer.
- R8: After a beat accepted with `s_tlast` high, the write pointer returns to 0, so the next frame overwrites the store from address 0.
- R9: A burst advances, and the outputs change, only on clock edges where `sample_en` is high. On other edges `tx_i`, `tx_q` and `tx_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Baseband sample strobe |
| s_tdata | input | 16 | Stream sample to store (signed) |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Last beat of a stream frame |
| cfg_last_idx | input | ADDR_W | Index of the last sample to play |
| cfg_use_ramp | input | 1 | 1 = ramp source, 0 = stored waveform |
| cfg_fire | input | 1 | Launch request (rising edge) |
| tx_i | output | 16 | In-phase output sample |
| tx_q | output | 16 | Quadrature output sample |
| tx_valid | output | 1 | Output sample valid |
| rx_start | output | 1 | One-cycle pulse to start capture |

## Verification
The bench builds the block with ADDR_W = 4, which gives a 16-entry store with a largest last index of 15. At that size a full-length burst, a burst at the top index and a write pointer that wraps past the end of the store all fit in a few dozen cycles. A relaunch request in the middle of a burst and gaps in the sample strobe can also be exercised against every stored address. The logic is the same as in the 2048-entry default build, so these results carry over to it.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
    localparam int unsigned WBP_SAMPLE_W = 16;

    typedef logic signed [WBP_SAMPLE_W-1:0] wbp_sample_t;

    // Ramp sample for a given burst index: starts at zero, one step per sample.
    function automatic wbp_sample_t wbp_ramp_sample(input logic [31:0] idx);
        return wbp_sample_t'(idx[WBP_SAMPLE_W-1:0]);
    endfunction
endpackage

// File: rtl/wbp_sample_ram.sv
module wbp_sample_ram #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_q <= mem_q[rd_addr];
        end
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/wbp_stream_writer.sv
module wbp_stream_writer #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (s_tvalid) begin
            if (s_tlast) begin
                st_d.ptr = '0;
            end else begin
                st_d.ptr = st_q.ptr + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = s_tvalid;
    assign wr_addr = st_q.ptr;

    // R1: a beat without last moves the pointer by one
    a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && !s_tlast) |=> (st_q.ptr == ADDR_W'($past(st_q.ptr) + ADDR_W'(1))));

    // R8: a beat with last returns the pointer to zero
    a_r8_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (s_tvalid && s_tlast) |=> (st_q.ptr == '0));
endmodule

// File: rtl/wbp_burst_ctrl.sv
module wbp_burst_ctrl #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              cfg_fire,
    input  logic [ADDR_W-1:0] cfg_last_idx,
    input  logic              cfg_use_ramp,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              src_ramp,
    output logic              rx_start
);
    typedef struct packed {
        logic              active;
        logic              fire_prev;
        logic              rx_start;
        logic              use_ramp;
        logic [ADDR_W-1:0] idx;
        logic [ADDR_W-1:0] last;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        launch;
    logic        step;

    always_comb begin
        launch       = cfg_fire && !st_q.fire_prev && !st_q.active;
        step         = st_q.active && sample_en;
        st_d         = st_q;
        st_d.fire_prev = cfg_fire;
        st_d.rx_start  = launch;
        if (launch) begin
            st_d.active   = 1'b1;
            st_d.idx      = '0;
            st_d.last     = cfg_last_idx;
            st_d.use_ramp = cfg_use_ramp;
        end else if (step) begin
            if (st_q.idx == st_q.last) begin
                st_d.active = 1'b0;
            end else begin
                st_d.idx = st_q.idx + ADDR_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_en    = step;
    assign rd_addr  = st_q.idx;
    assign src_ramp = st_q.use_ramp;
    assign rx_start = st_q.rx_start;

    // R2: the read index never passes the latched last index
    a_r2_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> (st_q.idx <= st_q.last));

    // R3: the step at the last index ends the burst
    a_r3_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && sample_en && (st_q.idx == st_q.last)) |=> !st_q.active);

    // R6: the capture start is a single-cycle pulse
    a_r6_rx_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !rx_start);

    // R7: no launch is taken while a burst runs
    a_r7_busy_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |=> !rx_start);
endmodule

// File: rtl/wave_burst_player.sv
module wave_burst_player
    import wbp_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en,
    input  logic [WBP_SAMPLE_W-1:0] s_tdata,
    input  logic                    s_tvalid,
    input  logic                    s_tlast,
    input  logic [ADDR_W-1:0]       cfg_last_idx,
    input  logic                    cfg_use_ramp,
    input  logic                    cfg_fire,
    output logic [WBP_SAMPLE_W-1:0] tx_i,
    output logic [WBP_SAMPLE_W-1:0] tx_q,
    output logic                    tx_valid,
    output logic                    rx_start
);
    localparam int unsigned SAMPLE_W = WBP_SAMPLE_W;

    typedef struct packed {
        logic        valid;
        logic        use_ramp;
        wbp_sample_t ramp;
    } out_state_t;

    logic                wr_en;
    logic [ADDR_W-1:0]   wr_addr;
    logic                rd_en;
    logic [ADDR_W-1:0]   rd_addr;
    logic [SAMPLE_W-1:0] rd_data;
    logic                src_ramp;
    out_state_t          out_d, out_q;
    logic [SAMPLE_W-1:0] sample_sel;

    wbp_stream_writer #(.ADDR_W(ADDR_W)) writer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_tvalid (s_tvalid),
        .s_tlast  (s_tlast),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr)
    );

    wbp_sample_ram #(.DATA_W(SAMPLE_W), .ADDR_W(ADDR_W)) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (s_tdata),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    wbp_burst_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_en    (sample_en),
        .cfg_fire     (cfg_fire),
        .cfg_last_idx (cfg_last_idx),
        .cfg_use_ramp (cfg_use_ramp),
        .rd_en        (rd_en),
        .rd_addr      (rd_addr),
        .src_ramp     (src_ramp),
        .rx_start     (rx_start)
    );

    // Output stage aligned with the one-cycle store read.
    always_comb begin
        out_d = out_q;
        if (sample_en) begin
            out_d.valid    = rd_en;
            out_d.use_ramp = src_ramp;
            out_d.ramp     = wbp_ramp_sample(32'(rd_addr));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        if (!out_q.valid) begin
            sample_sel = '0;
        end else if (out_q.use_ramp) begin
            sample_sel = out_q.ramp;
        end else begin
            sample_sel = rd_data;
        end
    end

    assign tx_i     = sample_sel;
    assign tx_q     = sample_sel;
    assign tx_valid = out_q.valid;

    // R9: outputs hold across edges without the sample strobe
    a_r9_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(tx_i) && $stable(tx_valid)));
endmodule

// File: tb/wave_burst_player_tb_top.sv
module wave_burst_player_tb_top;
    localparam int unsigned AW    = 4;
    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [AW-1:0] last;
        logic          ramp;
        logic          gaps;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{last: 4'd15, ramp: 1'b0, gaps: 1'b0},
        '{last: 4'd0,  ramp: 1'b0, gaps: 1'b0},
        '{last: 4'd7,  ramp: 1'b1, gaps: 1'b0},
        '{last: 4'd9,  ramp: 1'b0, gaps: 1'b1},
        '{last: 4'd15, ramp: 1'b1, gaps: 1'b1},
        '{last: 4'd3,  ramp: 1'b0, gaps: 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_en = 1'b0;
    logic [15:0]   s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tlast = 1'b0;
    logic [AW-1:0] cfg_last_idx = '0;
    logic          cfg_use_ramp = 1'b0;
    logic          cfg_fire = 1'b0;
    logic [15:0]   tx_i, tx_q;
    logic          tx_valid, rx_start;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [15:0] model [DEPTH];
    int mptr = 0;

    always #5 clk = ~clk;

    wave_burst_player #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
        .cfg_last_idx(cfg_last_idx), .cfg_use_ramp(cfg_use_ramp), .cfg_fire(cfg_fire),
        .tx_i(tx_i), .tx_q(tx_q), .tx_valid(tx_valid), .rx_start(rx_start)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] v, input logic last);
        @(negedge clk);
        s_tdata  = v;
        s_tvalid = 1'b1;
        s_tlast  = last;
        model[mptr] = v;
        mptr = last ? 0 : ((mptr + 1) % DEPTH);
    endtask

    task automatic push_end();
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    task automatic run_burst(input logic [AW-1:0] last, input logic ramp, input logic gaps);
        int cnt;
        logic en;
        logic [15:0] exp;
        cnt = 0;
        @(negedge clk);
        cfg_last_idx = last;
        cfg_use_ramp = ramp;
        cfg_fire     = 1'b1;
        sample_en    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(rx_start === 1'b1, "R6 rx_start at launch", int'(rx_start), 1);
        chk(tx_valid === 1'b0, "R6 no sample before strobe edge", int'(tx_valid), 0);
        for (int cyc = 0; cyc < 200; cyc++) begin
            en = gaps ? ((cyc % 3) != 2) : 1'b1;
            sample_en = en;
            if (cyc == 1) begin
                cfg_last_idx = ~last;   // R2/R4: ignored mid-burst
                cfg_use_ramp = ~ramp;
            end
            if (last >= 6 && cyc == 2) cfg_fire = 1'b0;
            if (last >= 6 && cyc == 3) cfg_fire = 1'b1;   // R7 refire mid-burst
            @(posedge clk);
            @(negedge clk);
            if (rx_start) chk(1'b0, "R7 relaunch during burst", 1, 0);
            chk(tx_i === tx_q, "R5 I equals Q", int'(tx_i), int'(tx_q));
            if (en) begin
                if (tx_valid) begin
                    exp = ramp ? 16'(cnt) : model[cnt % DEPTH];
                    chk(tx_i === exp, ramp ? "R4 ramp sample" : "R2 stored sample",
                        int'(tx_i), int'(exp));
                    cnt++;
                end else begin
                    chk(tx_i === 16'd0, "R5 zero when invalid", int'(tx_i), 0);
                    if (cnt > 0) break;
                end
            end
        end
        chk(cnt == int'(last) + 1, "R2 burst length", cnt, int'(last) + 1);
        sample_en = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (tx_valid !== 1'b0 || rx_start !== 1'b0)
                chk(1'b0, "R3 single burst with fire held", int'(tx_valid), 0);
        end
        checks++;
        cfg_fire = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < int'(DEPTH); i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_valid === 1'b0, "R5 reset valid low", int'(tx_valid), 0);
        chk(rx_start === 1'b0, "R6 reset rx_start low", int'(rx_start), 0);
        chk(tx_i === 16'd0, "R5 reset tx_i zero", int'(tx_i), 0);
        rst_n = 1'b1;

        // R1: full frame of signed samples, last on final beat
        for (int i = 0; i < int'(DEPTH); i++)
            push(16'(i * 1234 - 9000), i == int'(DEPTH) - 1);
        push_end();

        for (int v = 0; v < NVEC; v++)
            run_burst(VECS[v].last, VECS[v].ramp, VECS[v].gaps);

        // R8: short frame then new beats start again at 0
        push(16'h7fff, 1'b0);
        push(16'h8000, 1'b0);
        push(16'h1234, 1'b1);
        push(16'hbeef, 1'b0);
        push(16'h0042, 1'b0);
        push_end();
        run_burst(4'd15, 1'b0, 1'b0);

        // R1: pointer wraps past the end of the store
        for (int i = 0; i < int'(DEPTH) + 3; i++)
            push(16'(i * 77 + 5), 1'b0);
        push(16'hfff0, 1'b1);
        push_end();
        run_burst(4'd15, 1'b0, 1'b1);
        run_burst(4'd2, 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule